// File: doc/BRIEF.md
# Double-Buffered Frame-Synchronised Serial Port

This block is a 16-bit synchronous serial port with one word of buffering in each direction. On the receive side, a shift register collects bits from the serial data input. Each completed word moves into a receive holding register that the CPU reads. On the transmit side, the CPU writes a word into a transmit holding register. That word moves into a shift register when a transmit frame begins, and is then driven out one bit per serial clock.

Both directions follow strict flow-control rules. If the receive holding register is still unread when a new word completes, the new word is dropped, the holding register keeps its contents, and the receive interrupt stays silent until the CPU reads. A transmit interrupt is raised only when a word that the CPU wrote actually leaves the holding register. A transmit frame that finds the holding register empty sends zeros and raises a sticky underrun flag. A transmit frame sync that is already high when reset is released still starts a frame, so stale shift-register contents never reach the line.

The serial clock, the frame syncs and the serial data input are sampled in the system clock domain. Each of their levels must last at least two system clock cycles. Frame starts are qualified on the serial clock edge: a frame sync counts only when it is high at an edge and was low at the previous edge of the same kind.

Top module: `sersync_port`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the port clears everything. Afterwards `rx_data`, `rx_irq`, `tx_irq`, `rx_overrun`, `tx_underrun` and `sdo` are all 0, and the transmit holding register is empty.
- R2: A receive word starts on a falling `sclk` edge at which `rx_fs` is high and was low at the previous falling edge (or no falling edge has occurred since reset). That same edge samples the first bit. The remaining 15 bits are sampled on the following falling edges, most significant bit first.
- R3: A completed receive word is copied to `rx_data` when the holding register is empty or is being read (`rx_rd`) in that same cycle. In that case `rx_irq` is high for exactly one `clk` cycle, starting the cycle after the copy.
- R4: When a word completes while the holding register is full and not being read, the word is discarded, `rx_data` keeps its value and no `rx_irq` pulse occurs. Receive interrupts resume with the first word that completes after a read.
- R5: `rx_overrun` is set by a discarded receive word. It stays set until an `rx_rd` strobe, which clears it.
- R6: A transmit frame starts on a rising `sclk` edge at which `tx_fs` is high and was low at the previous rising edge (or no rising edge has occurred since reset). It sends 16 bits on `sdo`, most significant bit first, one bit per rising edge. `sdo` is 0 when no frame is active.
- R7: `tx_irq` pulses for one `clk` cycle when a frame start moves a buffered word into the shift register. No further pulse occurs until the CPU writes a new word with `tx_wr`.
- R8: A transmit frame that starts with an empty holding register sends 16 zero bits and sets `tx_underrun`. The flag stays set until the next `tx_wr`, which clears it.
- R9: If `tx_fs` is high when reset is released, the first rising `sclk` edge starts a frame. That frame sends zeros, because the holding register is empty. The first word written afterwards is the first buffered word transmitted.
- R10: Holding `tx_fs` high across the end of a frame does not start another frame. A new frame needs `tx_fs` low at one rising edge and high at a later one.
- R11: A new transmit frame may start on the rising edge right after the last bit's period, with no idle bit between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock, sampled on `clk` |
| rx_fs | input | 1 | Receive frame sync, active high |
| tx_fs | input | 1 | Transmit frame sync, active high |
| sdi | input | 1 | Serial receive data |
| rx_rd | input | 1 | CPU read strobe for the receive holding register |
| rx_data | output | 16 | Receive holding register contents |
| tx_wr | input | 1 | CPU write strobe for the transmit holding register |
| tx_wdata | input | 16 | Word to load into the transmit holding register |
| sdo | output | 1 | Serial transmit data |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_underrun | output | 1 | Sticky transmit underrun flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a receive overrun that lasts over several words and then recovers: the stimulus sends three complete words without reading, and only then reads once. The second is a transmit frame sync that is already high when reset is released. To reach it, the bench raises `tx_fs` while reset is still low and keeps it high through the first frame. The bench also holds `tx_fs` high across a word boundary, and it places a second frame start on the very edge that ends the previous word, which exercises the start qualification.

// File: rtl/sersync_pkg.sv
// Shared definitions for the serial port: default word width and the shifter phase.
package sersync_pkg;
    parameter int unsigned SP_WORD_W_DEF = 16;

    typedef enum logic {
        SP_IDLE  = 1'b0,
        SP_SHIFT = 1'b1
    } sp_phase_e;
endpackage

// File: rtl/sp_sclk_edge.sv
// Serial clock edge finder.
// Turns the sampled serial clock level into single-cycle rise and fall strobes.
// Assumes sclk is already synchronous to clk and holds each level for at least
// two clk cycles.
module sp_sclk_edge (
    input  logic clk,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember last cycle's level; no reset, so no false edge when reset is released.
    always_ff @(posedge clk) begin
        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sp_rx.sv
// Receive path: a shift register fed on falling serial clock edges, plus a
// one-word holding register with overrun protection and an interrupt pulse.
// Assumes W >= 2. A frame sync must be low at one falling edge before it can
// start another word.
module sp_rx
    import sersync_pkg::*;
#(
    parameter int unsigned W = SP_WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         fs,
    input  logic         sdi,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         irq,
    output logic         overrun
);
    localparam int unsigned CW = $clog2(W + 1);

    sp_phase_e    phase;
    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic          fs_low;
    logic          starting;
    logic          done;
    logic          free;
    logic [W-1:0]  word_in;

    // Decode the frame start, the word completion and buffer availability.
    always_comb begin
        starting = fall && (phase == SP_IDLE) && fs && fs_low;
        done     = fall && (phase == SP_SHIFT) && (cnt == CW'(W - 1));
        word_in  = {shreg[W-2:0], sdi};
        free     = ~full | rd;
    end

    // Shift serial bits in, most significant first, and count them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= SP_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            fs_low <= 1'b1;
        end else if (fall) begin
            fs_low <= ~fs;
            if (starting) begin
                shreg <= {{(W-1){1'b0}}, sdi};
                cnt   <= CW'(1);
                phase <= SP_SHIFT;
            end else if (phase == SP_SHIFT) begin
                shreg <= word_in;
                cnt   <= cnt + 1'b1;
                if (done) begin
                    phase <= SP_IDLE;
                end
            end
        end
    end

    // Move a completed word into the holding register unless it is still unread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            full    <= 1'b0;
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            irq <= done & free;
            if (done && free) begin
                rdata <= word_in;
                full  <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (done && !free) begin
                overrun <= 1'b1;
            end else if (rd) begin
                overrun <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sp_tx.sv
// Transmit path: a one-word holding register written by the CPU, and a shift
// register loaded from it at each qualified frame start and shifted out on
// rising serial clock edges. An empty holding register makes the frame send
// zeros and raises the underrun flag.
// Assumes W >= 2. The frame sync qualifier starts armed after reset, so a sync
// that is already high when reset is released still opens a frame.
module sp_tx
    import sersync_pkg::*;
#(
    parameter int unsigned W = SP_WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    input  logic         fs,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         sdo,
    output logic         full,
    output logic         irq,
    output logic         underrun
);
    localparam int unsigned CW = $clog2(W + 1);

    sp_phase_e     phase;
    logic [CW-1:0] cnt;
    logic [W-1:0]  shreg;
    logic [W-1:0]  hold_q;
    logic          fs_low;
    logic          last;
    logic          starting;

    // The last bit period ends on the rising edge after the LSB is driven.
    always_comb begin
        last     = (phase == SP_SHIFT) && (cnt == CW'(W));
        starting = rise && ((phase == SP_IDLE) || last) && fs && fs_low;
    end

    // Load the shift register at a frame start, then shift it out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= SP_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            fs_low <= 1'b1;
        end else if (rise) begin
            fs_low <= ~fs;
            if (starting) begin
                shreg <= full ? hold_q : '0;
                cnt   <= CW'(1);
                phase <= SP_SHIFT;
            end else if (phase == SP_SHIFT) begin
                shreg <= {shreg[W-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
                if (last) begin
                    phase <= SP_IDLE;
                end
            end
        end
    end

    // Keep the holding register, its full state, the interrupt and the underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            full     <= 1'b0;
            irq      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            irq <= starting & full;
            if (starting && full) begin
                full <= 1'b0;
            end
            if (starting && !full) begin
                underrun <= 1'b1;
            end
            if (wr) begin
                hold_q   <= wdata;
                full     <= 1'b1;
                underrun <= 1'b0;
            end
        end
    end

    assign sdo = shreg[W-1];
endmodule

// File: rtl/sersync_port.sv
// Double-buffered frame-synchronised serial port (top level).
// Connects the serial clock edge finder to the receive and transmit paths.
// Assumes all serial inputs are synchronous to clk. The reset is synchronous
// and active low.
module sersync_port
    import sersync_pkg::*;
#(
    parameter int unsigned WORD_W = SP_WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              rx_fs,
    input  logic              tx_fs,
    input  logic              sdi,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              sdo,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_overrun,
    output logic              tx_underrun
);
    logic sclk_rise;
    logic sclk_fall;
    logic rx_full;
    logic tx_full;

    sp_sclk_edge u_edge (
        .clk  (clk),
        .sclk (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    sp_rx #(.W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (sclk_fall),
        .fs      (rx_fs),
        .sdi     (sdi),
        .rd      (rx_rd),
        .rdata   (rx_data),
        .full    (rx_full),
        .irq     (rx_irq),
        .overrun (rx_overrun)
    );

    sp_tx #(.W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (sclk_rise),
        .fs       (tx_fs),
        .wr       (tx_wr),
        .wdata    (tx_wdata),
        .sdo      (sdo),
        .full     (tx_full),
        .irq      (tx_irq),
        .underrun (tx_underrun)
    );
endmodule

// File: rtl/sp_checker.sv
// Protocol checker for sersync_port, attached to it with a bind statement.
// It watches the buffer-state gating of interrupts and the sticky flag rules.
module sp_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_rd,
    input logic [W-1:0] rx_data,
    input logic         rx_full,
    input logic         rx_irq,
    input logic         rx_overrun,
    input logic         tx_wr,
    input logic         tx_full,
    input logic         tx_irq,
    input logic         tx_underrun
);
    // R3: a receive interrupt lasts a single cycle
    p_rx_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R4: an unread holding register is never overwritten
    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> $stable(rx_data));

    // R4: no receive interrupt while the holding register is unread
    p_rx_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> !rx_irq);

    // R5: the overrun flag is sticky until a read
    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_rd) |=> rx_overrun);

    // R5: a read clears the overrun flag
    p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> !rx_overrun);

    // R7: a transmit interrupt lasts a single cycle
    p_tx_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R7: no transmit interrupt without a buffered word
    p_tx_irq_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_full && !tx_wr) |=> !tx_irq);

    // R8: the underrun flag is sticky until a write
    p_udr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underrun && !tx_wr) |=> tx_underrun);

    // R8: a write clears the underrun flag
    p_udr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_underrun);
endmodule

bind sersync_port sp_checker #(.W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_rd       (rx_rd),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .rx_irq      (rx_irq),
    .rx_overrun  (rx_overrun),
    .tx_wr       (tx_wr),
    .tx_full     (tx_full),
    .tx_irq      (tx_irq),
    .tx_underrun (tx_underrun)
);

// File: tb/sim_sersync_port.sv
// Testbench for sersync_port: a queue-based reference model compared every
// cycle, plus directed checks of each requirement.
module sim_sersync_port;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        rx_fs = 1'b0;
    logic        tx_fs = 1'b0;
    logic        sdi = 1'b0;
    logic        rx_rd = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic [15:0] rx_data;
    logic        sdo, rx_irq, tx_irq, rx_overrun, tx_underrun;

    int n_tests = 0;
    int n_fail = 0;
    int rx_irq_cnt = 0;
    int tx_irq_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sersync_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .rx_fs(rx_fs), .tx_fs(tx_fs),
        .sdi(sdi), .rx_rd(rx_rd), .rx_data(rx_data), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .sdo(sdo), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
    );

    // Reference model state.
    bit          m_prev;
    bit          rq[$];
    bit          tq[$];
    bit          m_rfslow, m_tfslow, m_rfull, m_tfull;
    bit          m_rirq, m_tirq, m_rovr, m_tudr, m_sdo;
    logic [15:0] m_rdata, m_tbuf;

    always @(posedge clk) begin : ref_model
        bit rise, fall, done, tstart, free;
        logic [15:0] w;
        rise = sclk && !m_prev;
        fall = !sclk && m_prev;
        m_prev = sclk;
        if (!rst_n) begin
            rq.delete(); tq.delete();
            m_rfslow = 1; m_tfslow = 1; m_rfull = 0; m_tfull = 0;
            m_rirq = 0; m_tirq = 0; m_rovr = 0; m_tudr = 0; m_sdo = 0;
            m_rdata = '0; m_tbuf = '0;
        end else begin
            done = 0;
            w = '0;
            if (fall) begin
                if (rq.size() == 0) begin
                    if (rx_fs && m_rfslow) rq.push_back(sdi);
                end else begin
                    rq.push_back(sdi);
                    if (rq.size() == 16) begin
                        foreach (rq[i]) w = {w[14:0], rq[i]};
                        rq.delete();
                        done = 1;
                    end
                end
                m_rfslow = !rx_fs;
            end
            free = !m_rfull || rx_rd;
            m_rirq = done && free;
            if (done && free) begin
                m_rdata = w; m_rfull = 1;
            end else if (rx_rd) m_rfull = 0;
            if (done && !free) m_rovr = 1;
            else if (rx_rd) m_rovr = 0;

            tstart = 0;
            if (rise) begin
                if (tq.size() > 0) void'(tq.pop_front());
                if (tq.size() == 0 && tx_fs && m_tfslow) tstart = 1;
                m_tfslow = !tx_fs;
            end
            m_tirq = tstart && m_tfull;
            if (tstart) begin
                for (int i = 15; i >= 0; i--) tq.push_back(m_tfull ? m_tbuf[i] : 1'b0);
                if (m_tfull) m_tfull = 0;
                else m_tudr = 1;
            end
            if (tx_wr) begin
                m_tbuf = tx_wdata; m_tfull = 1; m_tudr = 0;
            end
            m_sdo = (tq.size() > 0) ? tq[0] : 1'b0;
        end
    end

    // Every-cycle comparison against the model, plus interrupt counting.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = 0;
            n_tests++;
            if (rx_data !== m_rdata) begin bad = 1; $display("FAIL R3 rx_data act=%h exp=%h", rx_data, m_rdata); end
            if (rx_irq !== m_rirq) begin bad = 1; $display("FAIL R3 rx_irq act=%b exp=%b", rx_irq, m_rirq); end
            if (rx_overrun !== m_rovr) begin bad = 1; $display("FAIL R5 rx_overrun act=%b exp=%b", rx_overrun, m_rovr); end
            if (tx_irq !== m_tirq) begin bad = 1; $display("FAIL R7 tx_irq act=%b exp=%b", tx_irq, m_tirq); end
            if (tx_underrun !== m_tudr) begin bad = 1; $display("FAIL R8 tx_underrun act=%b exp=%b", tx_underrun, m_tudr); end
            if (sdo !== m_sdo) begin bad = 1; $display("FAIL R6 sdo act=%b exp=%b", sdo, m_sdo); end
            if (bad) n_fail++;
            if (rx_irq === 1'b1) rx_irq_cnt++;
            if (tx_irq === 1'b1) tx_irq_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic period(input bit tfs, input bit rfs, input bit d, output bit cap);
        @(negedge clk);
        sclk = 1'b1; tx_fs = tfs;
        repeat (H) @(negedge clk);
        cap = sdo;
        sclk = 1'b0; rx_fs = rfs; sdi = d;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] rw, input bit rx_en, input bit tx_en,
                         input bit hold, output logic [15:0] tw);
        for (int i = 0; i < 16; i++) begin
            bit b;
            period(tx_en && (i == 0 || hold), rx_en && i == 0, rx_en ? rw[15-i] : 1'b0, b);
            tw[15-i] = b;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bit b;
            period(1'b0, 1'b0, 1'b0, b);
        end
    endtask

    task automatic cpu_wr(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic cpu_rd(output logic [15:0] w);
        @(negedge clk); w = rx_data; rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog act=hung exp=done");
            summary();
        end
    end

    initial begin : stimulus
        logic [15:0] tw, rw;
        int ti, ri;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 flags", {rx_overrun, tx_underrun}, 0);
        chk("R1 irq/sdo", {rx_irq, tx_irq, sdo}, 0);

        // R2 / R3 receive one word
        frame(16'hA5C3, 1, 0, 0, tw);
        idle(1);
        chk("R2 rx word", rx_data, 16'hA5C3);
        chk("R3 rx irq count", rx_irq_cnt, 1);
        cpu_rd(rw);

        // R6 / R7 transmit a buffered word while receiving
        cpu_wr(16'h1234);
        frame(16'h0F0F, 1, 1, 0, tw);
        chk("R6 tx word", tw, 16'h1234);
        chk("R7 tx irq count", tx_irq_cnt, 1);
        idle(1);
        chk("R3 rx second word", rx_data, 16'h0F0F);
        cpu_rd(rw);

        // R8 / R7 underrun on an empty holding register
        frame(16'h0, 0, 1, 0, tw);
        chk("R8 zero word", tw, 16'h0000);
        idle(2);
        chk("R8 underrun set", tx_underrun, 1);
        chk("R7 no irq without write", tx_irq_cnt, 1);
        cpu_wr(16'h8001);
        chk("R8 underrun cleared", tx_underrun, 0);
        frame(16'h0, 0, 1, 0, tw);
        chk("R6 tx 8001", tw, 16'h8001);
        chk("R7 irq after write", tx_irq_cnt, 2);

        // R4 / R5 overrun across several words
        frame(16'h1111, 1, 0, 0, tw);
        frame(16'h2222, 1, 0, 0, tw);
        frame(16'h3333, 1, 0, 0, tw);
        idle(1);
        chk("R4 buffer kept", rx_data, 16'h1111);
        chk("R4 no irq while unread", rx_irq_cnt, 3);
        chk("R5 overrun set", rx_overrun, 1);
        cpu_rd(rw);
        chk("R4 read value", rw, 16'h1111);
        chk("R5 overrun cleared", rx_overrun, 0);
        frame(16'h4444, 1, 0, 0, tw);
        idle(1);
        chk("R4 resumes", rx_data, 16'h4444);
        chk("R4 irq resumes", rx_irq_cnt, 4);
        cpu_rd(rw);

        // R11 back-to-back transmit frames
        cpu_wr(16'hABCD);
        frame(16'h0, 0, 1, 0, tw);
        chk("R11 first word", tw, 16'hABCD);
        cpu_wr(16'h5A5A);
        frame(16'h0, 0, 1, 0, tw);
        chk("R11 second word", tw, 16'h5A5A);
        chk("R11 irq count", tx_irq_cnt, 4);

        // R10 frame sync held high does not restart
        cpu_wr(16'hC3C3);
        frame(16'h0, 0, 1, 1, tw);
        chk("R10 held word", tw, 16'hC3C3);
        cpu_wr(16'h7E7E);
        ti = tx_irq_cnt;
        frame(16'h0, 0, 1, 1, tw);
        chk("R10 no restart", tw, 16'h0000);
        chk("R10 no irq", tx_irq_cnt, ti);
        chk("R10 no underrun", tx_underrun, 0);
        idle(1);
        frame(16'h0, 0, 1, 0, tw);
        chk("R10 after re-arm", tw, 16'h7E7E);

        // R9 frame sync high at reset release
        @(negedge clk);
        rst_n = 1'b0; tx_fs = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_data after reset", rx_data, 0);
        ti = tx_irq_cnt;
        ri = rx_irq_cnt;
        frame(16'h0, 0, 1, 1, tw);
        chk("R9 first frame zeros", tw, 16'h0000);
        chk("R9 underrun", tx_underrun, 1);
        chk("R9 no irq", tx_irq_cnt, ti);
        cpu_wr(16'hBEEF);
        idle(1);
        frame(16'h0, 0, 1, 0, tw);
        chk("R9 first written word", tw, 16'hBEEF);
        chk("R9 irq", tx_irq_cnt, ti + 1);
        chk("R1 no rx irq", rx_irq_cnt, ri);
        idle(2);
        summary();
    end
endmodule